// File: doc/BRIEF.md
# Weight-Pruned Compressed Correction Table

This block is a read-mostly correction table for a small streaming error decoder. Each lookup presents an 8-bit detection-event pattern. A pattern with more than three set bits is treated as too unlikely to be worth storing. For such a pattern the block answers "uncorrectable" and does not touch its storage. Every other pattern is mapped to a dense slot number. The slot number is the pattern's position among all 8-bit values of weight three or less, counted in ascending numeric order. There are 93 such values. The slot holds a 16-bit packed record, and the block expands it into a 36-bit correction word on the way out.

The packed record is sparse. It holds three 5-bit bit positions and a one-bit continuation marker. Expansion sets each named bit of the 36-bit word, and a slot holding the value 31 names no bit. The records are placed from outside through a sequential load port while lookups are blocked. Deciding which corrections go into the records is left to whatever fills the table.

Top module: `wprune_lut`

## Requirements
- R1: A lookup of a pattern with more than 3 set bits returns rsp_uncorr=1, with rsp_word=0 and rsp_more=0.
- R2: A pattern with 3 or fewer set bits returns the record at its dense slot. The dense slot is the count of 8-bit values that are numerically smaller than the pattern and have at most 3 set bits. Pattern 0x00 is slot 0, and 0xE0 is slot 92.
- R3: Packed record layout: bits [4:0], [9:5] and [14:10] are bit positions, and bit 15 is the continuation marker. Each position value from 0 to 30 sets that bit of rsp_word. The value 31 sets nothing. No other bit of rsp_word is set.
- R4: On a lookup of a pattern with 3 or fewer set bits, rsp_more carries bit 15 of the record and rsp_uncorr is 0.
- R5: A request is accepted on a clock edge where req_valid and req_ready are both high. rsp_valid is high for exactly one cycle, on the second edge after acceptance. Back-to-back requests give back-to-back responses in order.
- R6: While load_en is high, req_ready is low, and a req_valid in that time produces no response.
- R7: While load_en is low, the load position returns to slot 0. Each cycle with load_en and load_valid both high writes load_data to the current slot and then advances the position. Writes after slot 92 are dropped and do not wrap.
- R8: After reset, and in every cycle where rsp_valid is low, rsp_valid, rsp_word, rsp_more and rsp_uncorr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup may be accepted (low while loading) |
| req_addr | input | 8 | Event pattern to look up |
| rsp_valid | output | 1 | Response present |
| rsp_word | output | 36 | Expanded correction word |
| rsp_more | output | 1 | Continuation marker of the record |
| rsp_uncorr | output | 1 | Pattern exceeds the weight limit |
| load_en | input | 1 | Load mode; holds off lookups and arms the load position |
| load_valid | input | 1 | Load data present |
| load_data | input | 16 | Packed record to store at the current load position |

## Verification
The checks assume that the load port and the lookup port are never used at the same time. They also assume that no lookup of a stored pattern happens before its slot has been written, since storage is not reset. The stimulus fills all 93 slots before the first lookup, and it raises req_valid during load mode only to probe the hold-off. The records are drawn from a pattern that mixes empty positions, repeated positions and both marker values. The pipeline assertions assume that req_valid is driven to a known level from reset onwards.

// File: rtl/wprune_pkg.sv
package wprune_pkg;

   // binomial coefficient n choose k, zero outside 0..n
   function automatic int unsigned binom(input int n, input int k);
      int unsigned res;
      if (k < 0 || k > n) return 0;
      res = 1;
      for (int j = 1; j <= k; j++) res = res * (n - k + j) / j;
      return res;
   endfunction

   // number of n-bit values with at most r set bits
   function automatic int unsigned cum_binom(input int n, input int r);
      int unsigned s;
      s = 0;
      for (int j = 0; j <= r; j++) s += binom(n, j);
      return s;
   endfunction

endpackage

// File: rtl/wprune_rank.sv
module wprune_rank
   import wprune_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int MAX_WT = 3,
   parameter int DEPTH  = cum_binom(ADDR_W, MAX_WT),
   parameter int RANK_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [RANK_W-1:0] rank,
   output logic              over
);

   generate
      if (MAX_WT >= ADDR_W) begin : g_full
         // every pattern is kept; the dense slot is the pattern itself
         assign rank = RANK_W'(addr);
         assign over = 1'b0;
      end else begin : g_pruned
         always_comb begin : rank_calc
            int unsigned ones_v;
            int unsigned acc_v;
            ones_v = 0;
            acc_v  = 0;
            // walk from the top bit; each set bit counts the kept
            // values that agree above it and hold a zero in its place
            for (int i = ADDR_W - 1; i >= 0; i--) begin
               if (addr[i]) begin
                  for (int r = 0; r <= MAX_WT; r++) begin
                     if (ones_v == MAX_WT - r) acc_v += cum_binom(i, r);
                  end
                  ones_v++;
               end
            end
            over = (ones_v > MAX_WT);
            rank = RANK_W'(acc_v);
         end
      end
   endgenerate

endmodule

// File: rtl/wprune_store.sv
module wprune_store #(
   parameter int PACK_W = 16,
   parameter int DEPTH  = 93,
   parameter int RANK_W = 7,
   parameter int PTR_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic              load_valid,
   input  logic [PACK_W-1:0] load_data,
   input  logic              rd_en,
   input  logic [RANK_W-1:0] rd_idx,
   output logic [PACK_W-1:0] rd_data
);

   logic [PACK_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr;
   logic              wr_fire;

   initial begin
      if (PTR_W < $clog2(DEPTH + 1))
         $error("wprune_store: PTR_W too narrow for DEPTH");
      if ((1 << RANK_W) < DEPTH)
         $error("wprune_store: RANK_W too narrow for DEPTH");
   end

   assign wr_fire = load_en && load_valid && (wr_ptr < PTR_W'(DEPTH));

   // load position: parked at zero outside load mode, saturates at DEPTH
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wr_ptr <= '0;
      else if (!load_en) wr_ptr <= '0;
      else if (wr_fire)  wr_ptr <= wr_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_fire) mem[wr_ptr[RANK_W-1:0]] <= load_data;
   end

   // storage is read only for kept patterns
   always_ff @(posedge clk) begin
      if (rd_en) rd_data <= mem[rd_idx];
   end

   // R7
   ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ptr <= PTR_W'(DEPTH));

   // R2
   rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (rd_idx < RANK_W'(DEPTH)));

endmodule

// File: rtl/wprune_expand.sv
module wprune_expand #(
   parameter int PACK_W  = 16,
   parameter int ENTRY_W = 36,
   parameter int IDX_W   = 5,
   parameter int SLOTS   = 3
) (
   input  logic [PACK_W-1:0]  pack,
   output logic [ENTRY_W-1:0] word,
   output logic               more
);

   localparam int MORE_BIT = SLOTS * IDX_W;
   localparam logic [IDX_W-1:0] EMPTY = '1;

   initial begin
      if (PACK_W < MORE_BIT + 1)
         $error("wprune_expand: PACK_W cannot hold SLOTS positions and marker");
   end

   logic [ENTRY_W-1:0] slot_bits [SLOTS];

   genvar s;
   generate
      for (s = 0; s < SLOTS; s++) begin : g_slot
         logic [IDX_W-1:0] pos;
         assign pos = pack[s*IDX_W +: IDX_W];
         assign slot_bits[s] = (pos == EMPTY) ? '0
                             : (ENTRY_W'(1) << pos);
      end
   endgenerate

   always_comb begin
      word = '0;
      for (int k = 0; k < SLOTS; k++) word |= slot_bits[k];
   end

   assign more = pack[MORE_BIT];

endmodule

// File: rtl/wprune_lut.sv
module wprune_lut
   import wprune_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int MAX_WT  = 3,
   parameter int ENTRY_W = 36,
   parameter int IDX_W   = 5,
   parameter int SLOTS   = 3,
   parameter int PACK_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  req_addr,
   output logic               rsp_valid,
   output logic [ENTRY_W-1:0] rsp_word,
   output logic               rsp_more,
   output logic               rsp_uncorr,
   input  logic               load_en,
   input  logic               load_valid,
   input  logic [PACK_W-1:0]  load_data
);

   localparam int DEPTH  = cum_binom(ADDR_W, MAX_WT);
   localparam int RANK_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int PTR_W  = $clog2(DEPTH + 1);

   initial begin
      if (MAX_WT < 0 || ADDR_W < 1)
         $error("wprune_lut: bad ADDR_W / MAX_WT");
      if (DEPTH > 4096)
         $error("wprune_lut: DEPTH too large for inferred storage");
   end

   logic              fire;
   logic [RANK_W-1:0] rank;
   logic              over;
   logic              s1_valid, s1_over;
   logic [RANK_W-1:0] s1_rank;
   logic              s2_valid, s2_over;
   logic [PACK_W-1:0] rd_data;
   logic [ENTRY_W-1:0] exp_word;
   logic              exp_more;

   assign req_ready = !load_en;
   assign fire      = req_valid && req_ready;

   wprune_rank #(
      .ADDR_W (ADDR_W), .MAX_WT (MAX_WT), .DEPTH (DEPTH), .RANK_W (RANK_W)
   ) u_rank (
      .addr (req_addr), .rank (rank), .over (over)
   );

   // stage 1: slot number and weight verdict
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_over  <= 1'b0;
         s1_rank  <= '0;
      end else begin
         s1_valid <= fire;
         s1_over  <= over;
         s1_rank  <= rank;
      end
   end

   wprune_store #(
      .PACK_W (PACK_W), .DEPTH (DEPTH), .RANK_W (RANK_W), .PTR_W (PTR_W)
   ) u_store (
      .clk (clk), .rst_n (rst_n),
      .load_en (load_en), .load_valid (load_valid), .load_data (load_data),
      .rd_en (s1_valid && !s1_over), .rd_idx (s1_rank), .rd_data (rd_data)
   );

   // stage 2: read data arrives alongside the verdict
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
         s2_over  <= 1'b0;
      end else begin
         s2_valid <= s1_valid;
         s2_over  <= s1_over;
      end
   end

   wprune_expand #(
      .PACK_W (PACK_W), .ENTRY_W (ENTRY_W), .IDX_W (IDX_W), .SLOTS (SLOTS)
   ) u_expand (
      .pack (rd_data), .word (exp_word), .more (exp_more)
   );

   assign rsp_valid  = s2_valid;
   assign rsp_uncorr = s2_valid && s2_over;
   assign rsp_word   = (s2_valid && !s2_over) ? exp_word : '0;
   assign rsp_more   = s2_valid && !s2_over && exp_more;

   // R5
   accept_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> s1_valid);

   // R5
   rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> rsp_valid);

   // R5
   no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_valid |=> !rsp_valid);

   // R6
   load_holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |-> !req_ready);

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (rsp_word == '0 && !rsp_more && !rsp_uncorr));

   // R3
   sparse_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($countones(rsp_word) <= SLOTS));

endmodule

// File: tb/wprune_lut_tb.sv
module wprune_lut_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [7:0]  req_addr = '0;
   logic        rsp_valid;
   logic [35:0] rsp_word;
   logic        rsp_more;
   logic        rsp_uncorr;
   logic        load_en = 1'b0;
   logic        load_valid = 1'b0;
   logic [15:0] load_data = '0;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   bit slot0_override = 0;
   logic [15:0] slot0_val = '0;

   always #10 clk = ~clk;

   wprune_lut u_dut (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
      .rsp_valid (rsp_valid), .rsp_word (rsp_word), .rsp_more (rsp_more),
      .rsp_uncorr (rsp_uncorr),
      .load_en (load_en), .load_valid (load_valid), .load_data (load_data)
   );

   // {pattern, expected uncorrectable}
   localparam logic [8:0] VEC [12] = '{
      {8'h00, 1'b0}, {8'h01, 1'b0}, {8'h80, 1'b0}, {8'hFF, 1'b1},
      {8'h07, 1'b0}, {8'h0F, 1'b1}, {8'hE0, 1'b0}, {8'hF0, 1'b1},
      {8'hA8, 1'b0}, {8'h55, 1'b1}, {8'h92, 1'b0}, {8'hFE, 1'b1}
   };

   function automatic logic [15:0] rec_of(input int k);
      logic [4:0] a, b, c;
      a = 5'(k % 31);
      b = 5'((k * 7 + 3) % 32);
      c = (k % 5 == 0) ? 5'd31 : 5'((k * 3) % 31);
      return {k[0], c, b, a};
   endfunction

   function automatic int slot_of(input logic [7:0] p);
      int n = 0;
      for (int v = 0; v < p; v++) if ($countones(8'(v)) <= 3) n++;
      return n;
   endfunction

   function automatic logic [35:0] spread(input logic [15:0] r);
      logic [35:0] w = '0;
      for (int s = 0; s < 3; s++) begin
         logic [4:0] f = r[s*5 +: 5];
         if (f != 5'd31) w[f] = 1'b1;
      end
      return w;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // compare the current response against the model for pattern p
   task automatic check_rsp(input logic [7:0] p);
      logic [15:0] r;
      bit unc = ($countones(p) > 3);
      int k = slot_of(p);
      r = (k == 0 && slot0_override) ? slot0_val : rec_of(k);
      check(rsp_valid === 1'b1, "R5", "rsp_valid", 64'(rsp_valid), 64'd1);
      if (unc) begin
         check(rsp_uncorr === 1'b1 && rsp_word === '0 && rsp_more === 1'b0,
               "R1", $sformatf("pattern %0h", p),
               {26'd0, rsp_uncorr, rsp_more, rsp_word}, {26'd0, 2'b10, 36'd0});
      end else begin
         check(rsp_word === spread(r), "R2", $sformatf("pattern %0h word", p),
               64'(rsp_word), 64'(spread(r)));
         check(rsp_more === r[15] && rsp_uncorr === 1'b0, "R4",
               $sformatf("pattern %0h flags", p),
               {62'd0, rsp_uncorr, rsp_more}, {62'd0, 1'b0, r[15]});
      end
   endtask

   task automatic lookup(input logic [7:0] p);
      @(negedge clk);
      req_valid = 1'b1; req_addr = p;
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid === 1'b0, "R5", "early response", 64'(rsp_valid), 64'd0);
      @(negedge clk);
      check_rsp(p);
      @(negedge clk);
      check(rsp_valid === 1'b0, "R5", "response width", 64'(rsp_valid), 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state
      check(rsp_valid === 1'b0 && rsp_word === '0 && rsp_uncorr === 1'b0
            && rsp_more === 1'b0, "R8", "reset outputs",
            {26'd0, rsp_valid, rsp_uncorr, rsp_word}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready === 1'b1, "R6", "ready when idle", 64'(req_ready), 64'd1);

      // R7: fill every slot, then two extra writes that must be dropped
      load_en = 1'b1;
      @(negedge clk);
      check(req_ready === 1'b0, "R6", "ready during load", 64'(req_ready), 64'd0);
      for (int k = 0; k < 95; k++) begin
         load_valid = 1'b1;
         load_data = (k < 93) ? rec_of(k) : 16'h7FFF ^ 16'(k);
         @(negedge clk);
      end
      load_valid = 1'b0;
      // R6: a request while loading is not taken
      req_valid = 1'b1; req_addr = 8'h01;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (3) begin
         @(negedge clk);
         check(rsp_valid === 1'b0, "R6", "response while loading", 64'(rsp_valid), 64'd0);
      end
      load_en = 1'b0;
      @(negedge clk);

      // table walk, pipelined back to back (R5, R1, R2, R4)
      for (int i = 0; i < 14; i++) begin
         if (i >= 2) check_rsp(VEC[i-2][8:1]);
         if (i < 12) begin
            check(rsp_uncorr === ((i >= 2) ? VEC[i-2][0] : 1'b0) || i < 2,
                  "R1", "flag against table", 64'(rsp_uncorr), 64'(VEC[(i>=2)?i-2:0][0]));
            req_valid = 1'b1; req_addr = VEC[i][8:1];
         end else req_valid = 1'b0;
         @(negedge clk);
      end
      req_valid = 1'b0;
      @(negedge clk);
      check(rsp_valid === 1'b0, "R5", "pipeline drained", 64'(rsp_valid), 64'd0);

      // R2: full sweep of every pattern, back to back
      for (int i = 0; i < 258; i++) begin
         if (i >= 2) check_rsp(8'(i - 2));
         req_valid = (i < 256); req_addr = 8'(i);
         @(negedge clk);
      end
      req_valid = 1'b0;

      // R7: slot 0 still holds its first record (no wrap), last slot intact
      lookup(8'h00);
      lookup(8'hE0);

      // R3: a record with an empty slot and a repeated position
      load_en = 1'b1;
      @(negedge clk);
      load_valid = 1'b1; load_data = {1'b1, 5'd31, 5'd30, 5'd30};
      @(negedge clk);
      load_valid = 1'b0; load_en = 1'b0;
      slot0_override = 1'b1; slot0_val = {1'b1, 5'd31, 5'd30, 5'd30};
      lookup(8'h00);
      check(rsp_word === '0, "R8", "word idle after response", 64'(rsp_word), 64'd0);
      // R3: all empty
      load_en = 1'b1;
      @(negedge clk);
      load_valid = 1'b1; load_data = 16'h7FFF;
      @(negedge clk);
      load_valid = 1'b0; load_en = 1'b0;
      slot0_val = 16'h7FFF;
      lookup(8'h00);
      lookup(8'h01);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule